// File: doc/BRIEF.md
# Dual-Port Address Conflict Arbiter

This block sits in front of a two-port shared memory and decides which port may touch a word when both ports reach for it at once. Each side presents a select, an address, a write strobe and per-byte enables. When both sides are selected on the same address, one side is granted and the other side gets an active-low busy flag. That flag stays low until the granted side leaves the shared word. Outputs per side are the gated access grant, write strobe and byte enables that the array behind the block uses directly.

The winner follows the order in which the collision formed. If the shared address was already on both address buses and one select arrived earlier, that select wins. If both selects were already active and one address moved onto the other, the port whose address was there first wins. A same-cycle start goes to the left side. A strap input picks master or slave operation. A master computes busy and drives it out. A slave drives no busy of its own and instead takes busy flags from an external master, using them to hold off writes during a collision that the master is still resolving.

The block is synchronous. Its only state is a one-cycle history of each port's select and address, plus the current owner of a running collision. Busy, grant and write outputs are combinational from the present inputs and that state, so a losing write is blocked in the very cycle the collision begins.

Top module: `dp_conflict_arb`

## Requirements
- R1: A collision exists only when both selects are high and both addresses are equal. With no collision, a master holds both busy outputs high.
- R2: Select-first. Suppose the addresses were equal and unchanged over the previous and present cycle, and exactly one select was high in the previous cycle. When the other select rises, the earlier port wins and the later port's busy output goes low in that same cycle.
- R3: Address-first. Suppose both selects were high in the previous cycle, and one port's address is unchanged while the other port's address moves onto it. The unchanged port wins and the moving port's busy output goes low in that same cycle.
- R4: When a collision starts with neither select high in the previous cycle (or with no earlier claim on either side), the left port wins and only the right busy output goes low.
- R5: Busy is asserted only toward the losing port. The two busy outputs are never low together.
- R6: Once decided, the winner keeps the word for as long as the collision lasts, whichever side that is. Busy rises in the cycle the winner drops its select or changes its address. If the winner then returns to the same word while the loser is still waiting, the loser wins.
- R7: With the strap high (master), busy outputs carry the local decision. With the strap low (slave), both busy outputs stay high and the busy inputs set the blocking instead.
- R8: In slave mode, a port whose busy input is low has its write strobe, grant and byte-enable outputs forced to zero. With its busy input high, they pass through: grant = select, write = select AND write strobe, and byte enables = bit 1 upper, bit 0 lower as presented while selected.
- R9: In master mode, the losing port's grant, write strobe and byte enables are forced to zero while its busy is low. The winner's pass through unchanged.
- R10: During reset and right after it, both busy outputs are high and no collision owner is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Strap: 1 = master (local arbitration), 0 = slave (external busy) |
| l_sel | input | 1 | Left port select, active high |
| l_addr | input | 13 | Left port word address |
| l_wr | input | 1 | Left port write strobe |
| l_be | input | 2 | Left byte enables, bit 1 upper, bit 0 lower |
| l_busy_in_n | input | 1 | Left busy from external master (slave mode), active low |
| l_busy_out_n | output | 1 | Left busy toward the left port, active low |
| l_grant | output | 1 | Left access allowed this cycle |
| l_we | output | 1 | Left gated write strobe to the array |
| l_be_out | output | 2 | Left gated byte enables |
| r_sel | input | 1 | Right port select, active high |
| r_addr | input | 13 | Right port word address |
| r_wr | input | 1 | Right port write strobe |
| r_be | input | 2 | Right byte enables, bit 1 upper, bit 0 lower |
| r_busy_in_n | input | 1 | Right busy from external master (slave mode), active low |
| r_busy_out_n | output | 1 | Right busy toward the right port, active low |
| r_grant | output | 1 | Right access allowed this cycle |
| r_we | output | 1 | Right gated write strobe to the array |
| r_be_out | output | 2 | Right gated byte enables |

## Verification
Some properties are checked every cycle:
- busy never falls without a collision;
- the two busy flags are never low together;
- a slave never drives busy;
- a blocked port never gets a write strobe or byte enable;
- the owner of a running collision never changes.

Each ordering rule (select-first, address-first, same-cycle tie) is also checked on every cycle in which its history pattern appears. Only the directed scenarios show the rest:
- a right-side winner keeps the word across several cycles;
- busy releases in the exact cycle the winner leaves;
- a winner that re-enters the word loses to the waiting port;
- slave mode follows each busy input independently per side.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int SIDE_L    = 0;
   localparam int SIDE_R    = 1;
   localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dpca_port_track.sv
// One-cycle history of a port: was it already presenting this address?
module dpca_port_track #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              was_ready
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         sel_q  <= sel;
         addr_q <= addr;
      end
   end

   // Claim on the current word is older than this cycle.
   assign was_ready = sel_q && (addr_q == addr);
endmodule

// File: rtl/dpca_resolver.sv
// Picks and holds the owner of a collision.
module dpca_resolver
   import dpca_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   conflict,
   input  logic   ready_l,
   input  logic   ready_r,
   output owner_e winner
);
   owner_e owner_q;
   logic   hist_ok;

   always_comb begin
      winner = OWN_NONE;
      if (conflict) begin
         if (owner_q != OWN_NONE)      winner = owner_q;
         else if (ready_r && !ready_l) winner = OWN_RIGHT;
         else                          winner = OWN_LEFT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         hist_ok <= 1'b0;
      end else begin
         owner_q <= winner;
         hist_ok <= 1'b1;
      end
   end

   // R6: owner is stable while the collision continues
   a_r6_owner_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && conflict && $past(conflict)) |-> (winner == $past(winner)));
endmodule

// File: rtl/dpca_gate.sv
// Blocks a port's access outputs while its effective busy is low.
module dpca_gate #(
   parameter int NUM_BYTES = 2
) (
   input  logic                 sel,
   input  logic                 wr,
   input  logic [NUM_BYTES-1:0] be,
   input  logic                 busy_n,
   output logic                 grant,
   output logic                 we,
   output logic [NUM_BYTES-1:0] be_out
);
   always_comb begin
      grant  = sel && busy_n;
      we     = grant && wr;
      be_out = grant ? be : '0;
   end

   // R8/R9: a blocked port issues nothing
   always_comb begin
      if (busy_n == 1'b0) begin
         a_r8_blocked_quiet: assert (!we && !grant && (be_out == '0));
      end
   end
endmodule

// File: rtl/dp_conflict_arb.sv
module dp_conflict_arb
   import dpca_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int NUM_BYTES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 is_master,
   input  logic                 l_sel,
   input  logic [ADDR_W-1:0]    l_addr,
   input  logic                 l_wr,
   input  logic [NUM_BYTES-1:0] l_be,
   input  logic                 l_busy_in_n,
   output logic                 l_busy_out_n,
   output logic                 l_grant,
   output logic                 l_we,
   output logic [NUM_BYTES-1:0] l_be_out,
   input  logic                 r_sel,
   input  logic [ADDR_W-1:0]    r_addr,
   input  logic                 r_wr,
   input  logic [NUM_BYTES-1:0] r_be,
   input  logic                 r_busy_in_n,
   output logic                 r_busy_out_n,
   output logic                 r_grant,
   output logic                 r_we,
   output logic [NUM_BYTES-1:0] r_be_out
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("dp_conflict_arb: ADDR_W must be at least 1");
      end
      if (NUM_BYTES < 1) begin : g_bad_bytes
         $error("dp_conflict_arb: NUM_BYTES must be at least 1");
      end
   endgenerate

   logic [NUM_SIDES-1:0]                sel_v, wr_v, ready_v, busy_in_v;
   logic [NUM_SIDES-1:0]                calc_busy_n, eff_busy_n;
   logic [NUM_SIDES-1:0]                grant_v, we_v;
   logic [NUM_SIDES-1:0][ADDR_W-1:0]    addr_v;
   logic [NUM_SIDES-1:0][NUM_BYTES-1:0] be_v, be_out_v;
   logic                                conflict;
   owner_e                              winner;

   assign sel_v     = {r_sel, l_sel};
   assign wr_v      = {r_wr, l_wr};
   assign addr_v    = {r_addr, l_addr};
   assign be_v      = {r_be, l_be};
   assign busy_in_v = {r_busy_in_n, l_busy_in_n};

   assign conflict = sel_v[SIDE_L] && sel_v[SIDE_R] &&
                     (addr_v[SIDE_L] == addr_v[SIDE_R]);

   dpca_resolver u_resolver (
      .clk      (clk),
      .rst_n    (rst_n),
      .conflict (conflict),
      .ready_l  (ready_v[SIDE_L]),
      .ready_r  (ready_v[SIDE_R]),
      .winner   (winner)
   );

   assign calc_busy_n[SIDE_L] = !(conflict && (winner == OWN_RIGHT));
   assign calc_busy_n[SIDE_R] = !(conflict && (winner == OWN_LEFT));

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel_v[s]),
            .addr      (addr_v[s]),
            .was_ready (ready_v[s])
         );

         assign eff_busy_n[s] = is_master ? calc_busy_n[s] : busy_in_v[s];

         dpca_gate #(.NUM_BYTES(NUM_BYTES)) u_gate (
            .sel    (sel_v[s]),
            .wr     (wr_v[s]),
            .be     (be_v[s]),
            .busy_n (eff_busy_n[s]),
            .grant  (grant_v[s]),
            .we     (we_v[s]),
            .be_out (be_out_v[s])
         );
      end
   endgenerate

   assign l_busy_out_n = is_master ? calc_busy_n[SIDE_L] : 1'b1;
   assign r_busy_out_n = is_master ? calc_busy_n[SIDE_R] : 1'b1;
   assign l_grant      = grant_v[SIDE_L];
   assign r_grant      = grant_v[SIDE_R];
   assign l_we         = we_v[SIDE_L];
   assign r_we         = we_v[SIDE_R];
   assign l_be_out     = be_out_v[SIDE_L];
   assign r_be_out     = be_out_v[SIDE_R];

   // ---------------- port-level checks ----------------
   logic hist_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) hist_ok <= 1'b0;
      else        hist_ok <= 1'b1;
   end

   a_r1_no_busy_without_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_sel && r_sel && (l_addr == r_addr)) |-> (l_busy_out_n && r_busy_out_n));

   a_r5_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy_out_n || r_busy_out_n));

   a_r7_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> (l_busy_out_n && r_busy_out_n));

   a_r2_select_first_left: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && is_master && conflict && !$past(conflict) &&
       $past(l_sel && !r_sel) && $stable(l_addr) && $stable(r_addr))
      |-> (!r_busy_out_n && l_busy_out_n));

   a_r2_select_first_right: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && is_master && conflict && !$past(conflict) &&
       $past(r_sel && !l_sel) && $stable(l_addr) && $stable(r_addr))
      |-> (!l_busy_out_n && r_busy_out_n));

   a_r3_address_first_left: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && is_master && conflict && !$past(conflict) &&
       $past(l_sel && r_sel) && $stable(l_addr) && !$stable(r_addr))
      |-> !r_busy_out_n);

   a_r3_address_first_right: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && is_master && conflict && !$past(conflict) &&
       $past(l_sel && r_sel) && $stable(r_addr) && !$stable(l_addr))
      |-> !l_busy_out_n);

   a_r4_tie_goes_left: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && is_master && conflict && !$past(l_sel) && !$past(r_sel))
      |-> (!r_busy_out_n && l_busy_out_n));
endmodule

// File: tb/tb_dp_conflict_arb.sv
module tb_dp_conflict_arb;
   localparam int AW = 13;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n, is_master;
   logic          l_sel, l_wr, l_busy_in_n, r_sel, r_wr, r_busy_in_n;
   logic [AW-1:0] l_addr, r_addr;
   logic [NB-1:0] l_be, r_be;
   logic          l_busy_out_n, r_busy_out_n, l_grant, r_grant, l_we, r_we;
   logic [NB-1:0] l_be_out, r_be_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   dp_conflict_arb #(.ADDR_W(AW), .NUM_BYTES(NB)) dut (
      .clk(clk), .rst_n(rst_n), .is_master(is_master),
      .l_sel(l_sel), .l_addr(l_addr), .l_wr(l_wr), .l_be(l_be),
      .l_busy_in_n(l_busy_in_n), .l_busy_out_n(l_busy_out_n),
      .l_grant(l_grant), .l_we(l_we), .l_be_out(l_be_out),
      .r_sel(r_sel), .r_addr(r_addr), .r_wr(r_wr), .r_be(r_be),
      .r_busy_in_n(r_busy_in_n), .r_busy_out_n(r_busy_out_n),
      .r_grant(r_grant), .r_we(r_we), .r_be_out(r_be_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive at the falling edge, sample 5 ns later (well before the rising edge).
   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic settle();
      #5;
   endtask

   task automatic idle();
      cyc();
      l_sel = 0; r_sel = 0; l_wr = 0; r_wr = 0;
      l_be = 2'b11; r_be = 2'b11; l_addr = '0; r_addr = '0;
      l_busy_in_n = 1; r_busy_in_n = 1;
      settle();
   endtask

   task automatic t_reset();
      check("R10 l_busy", int'(l_busy_out_n), 1);
      check("R10 r_busy", int'(r_busy_out_n), 1);
      idle();
      l_sel = 1; r_sel = 1; l_addr = 9; r_addr = 9; settle();
      check("R10 first tie after reset r_busy", int'(r_busy_out_n), 0);
      check("R10 first tie after reset l_busy", int'(l_busy_out_n), 1);
      idle();
   endtask

   task automatic t_no_conflict();
      cyc(); l_sel = 1; r_sel = 1; l_addr = 100; r_addr = 101; settle();
      check("R1 diff addr l_busy", int'(l_busy_out_n), 1);
      check("R1 diff addr r_busy", int'(r_busy_out_n), 1);
      idle();
      cyc(); l_sel = 1; l_addr = 55; r_addr = 55; settle();
      check("R1 one select r_busy", int'(r_busy_out_n), 1);
      check("R1 one select l_grant", int'(l_grant), 1);
      idle();
   endtask

   task automatic t_select_first();
      cyc(); l_sel = 1; l_addr = 5; r_addr = 5; settle();
      cyc(); r_sel = 1; r_wr = 1; settle();
      check("R2 left earlier r_busy", int'(r_busy_out_n), 0);
      check("R5 left earlier l_busy", int'(l_busy_out_n), 1);
      check("R9 loser we", int'(r_we), 0);
      check("R9 loser grant", int'(r_grant), 0);
      idle();
      cyc(); r_sel = 1; l_addr = 6; r_addr = 6; settle();
      cyc(); l_sel = 1; settle();
      check("R2 right earlier l_busy", int'(l_busy_out_n), 0);
      check("R5 right earlier r_busy", int'(r_busy_out_n), 1);
      idle();
   endtask

   task automatic t_address_first();
      cyc(); l_sel = 1; r_sel = 1; l_addr = 10; r_addr = 20; settle();
      cyc(); r_addr = 10; settle();
      check("R3 right moves r_busy", int'(r_busy_out_n), 0);
      check("R3 right moves l_busy", int'(l_busy_out_n), 1);
      idle();
      cyc(); l_sel = 1; r_sel = 1; l_addr = 10; r_addr = 20; settle();
      cyc(); l_addr = 20; settle();
      check("R3 left moves l_busy", int'(l_busy_out_n), 0);
      check("R3 left moves r_busy", int'(r_busy_out_n), 1);
      idle();
   endtask

   task automatic t_tie();
      cyc(); l_sel = 1; r_sel = 1; l_addr = 7; r_addr = 7; settle();
      check("R4 tie r_busy", int'(r_busy_out_n), 0);
      check("R4 tie l_busy", int'(l_busy_out_n), 1);
      idle();
   endtask

   task automatic t_hold_release();
      // Left wins by tie, then holds while writing
      cyc(); l_sel = 1; r_sel = 1; l_addr = 7; r_addr = 7;
      l_wr = 1; r_wr = 1; l_be = 2'b10; settle();
      for (int k = 0; k < 3; k++) begin
         cyc(); settle();
         check("R6 left holds r_busy", int'(r_busy_out_n), 0);
         check("R9 winner we", int'(l_we), 1);
         check("R9 winner be_out", int'(l_be_out), 2);
      end
      cyc(); l_addr = 8; settle();
      check("R6 release on addr change r_busy", int'(r_busy_out_n), 1);
      check("R9 released r_we", int'(r_we), 1);
      idle();
      // Right wins by select-first, keeps the word across cycles
      cyc(); r_sel = 1; l_addr = 3; r_addr = 3; settle();
      cyc(); l_sel = 1; settle();
      check("R6 right wins l_busy", int'(l_busy_out_n), 0);
      for (int k = 0; k < 2; k++) begin
         cyc(); settle();
         check("R6 right holds l_busy", int'(l_busy_out_n), 0);
         check("R6 right holds r_busy", int'(r_busy_out_n), 1);
      end
      cyc(); r_sel = 0; settle();
      check("R6 release on deselect l_busy", int'(l_busy_out_n), 1);
      cyc(); r_sel = 1; settle();
      check("R6 waiting port wins r_busy", int'(r_busy_out_n), 0);
      check("R6 waiting port wins l_busy", int'(l_busy_out_n), 1);
      idle();
   endtask

   task automatic t_slave();
      cyc(); is_master = 0; l_sel = 1; r_sel = 1; l_addr = 7; r_addr = 7;
      l_wr = 1; r_wr = 1; l_be = 2'b01; r_be = 2'b10; settle();
      check("R7 slave l_busy_out", int'(l_busy_out_n), 1);
      check("R7 slave r_busy_out", int'(r_busy_out_n), 1);
      check("R8 slave free r_we", int'(r_we), 1);
      check("R8 slave free l_be_out", int'(l_be_out), 1);
      cyc(); r_busy_in_n = 0; settle();
      check("R8 slave blocked r_we", int'(r_we), 0);
      check("R8 slave blocked r_be_out", int'(r_be_out), 0);
      check("R8 slave other l_we", int'(l_we), 1);
      cyc(); r_busy_in_n = 1; l_busy_in_n = 0; settle();
      check("R8 slave blocked l_we", int'(l_we), 0);
      check("R8 slave released r_be_out", int'(r_be_out), 2);
      cyc(); is_master = 1; settle();
      idle();
   endtask

   initial begin
      rst_n = 0; is_master = 1;
      l_sel = 0; r_sel = 0; l_wr = 0; r_wr = 0; l_be = 2'b11; r_be = 2'b11;
      l_addr = '0; r_addr = '0; l_busy_in_n = 1; r_busy_in_n = 1;
      repeat (3) @(negedge clk);
      #5;
      check("R10 reset l_busy", int'(l_busy_out_n), 1);
      check("R10 reset r_busy", int'(r_busy_out_n), 1);
      @(negedge clk); rst_n = 1;
      #5;
      t_reset();
      t_no_conflict();
      t_select_first();
      t_address_first();
      t_tie();
      t_hold_release();
      t_slave();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule